// File: doc/BRIEF.md
# Sleep-State Wake and Power-Loss Controller

This block holds the wake logic of a system power manager. It tracks which sleep state the platform is in and, for the deepest soft-off state, how that state was reached. The three ways in are a software sleep command, a power loss, and a forced power-button override. Level-sensitive wake inputs set sticky status bits. Status bits are cleared by write-one-to-clear. Per-source enables, together with the entry path, decide which status rises may wake the machine. When one does, the block raises a one-clock wake request and returns the state to working.

The block also watches the core power-good input and the resume-well reset. It keeps two sticky failure flags for them and applies a power-return policy. While the resume well is held in reset, most status and enable bits are wiped. The alarm enable survives the loss. A pending ring-indicate event survives the loss and forces a boot.

Top module: `wake_pm_ctrl`

## Requirements
- R1: After `rst_ni` is asserted, the block is in the following state. `state_o` is 5 (S5). `s5_entry_o` is 1 (power loss). `sts_o` is 0. `en_o` reads only the fixed bits 0 and 4. `wake_o`, `core_flr_o` and `pwr_flr_o` are 0.
- R2: `core_flr_o` sets when `pwr_good_i` is sampled high on one edge and low on the next. `pwr_flr_o` sets on every edge that samples `rsm_rst_ni` low. Both flags are sticky. Each is cleared by writing 1 to `flr_clr_i` (bit 0 for the core flag, bit 1 for the power flag). A set in the same cycle wins over the clear.
- R3: On every edge that samples `rsm_rst_ni` low, the block does the following. It clears all status bits except ring (bit 1). It clears all enable bits except the alarm enable (bit 2). It ignores enable writes and status clears.
- R4: A low `ring_ni` while the resume well is in reset sets the ring status bit. That bit is kept through the loss. A set ring status on power return causes a boot, whatever the policy.
- R5: On the first edge with `rsm_rst_ni` high after a loss, the block picks one of three outcomes. It enters S0 and pulses `wake_o` if `stay_off_i` is 0 or the ring status is set. Otherwise it enters S4 if it was in S4 when the loss began. In every other case it enters S5 with `s5_entry_o` = 1. During the loss, `state_o` reads 7.
- R6: Each status bit sets while its source is active and the resume well is out of reset. The bit layout is: bit 0, `pwr_btn_ni` low; bit 1, `ring_ni` low; bit 2, `rtc_alarm_i`; bit 3, `pme_i`; bit 4, an SMBus message with code 01h, 03h or 04h; bit 5+k, `gp_wake_i[k]`. Other SMBus codes are ignored. `sts_clr_i` clears the bits set in `sts_clr_mask_i`, and a set in the same cycle wins.
- R7: `en_wr_i` loads `en_wdata_i` into the enable register. `en_o` bits 0 (button) and 4 (SMBus) always read 1.
- R8: While in S1, S3, S4 or S5, an eligible status bit may go from 0 to 1. In the same edge that sets it, `wake_o` goes high for exactly one cycle and `state_o` becomes 0.
- R9: In S5, when `s5_entry_o` is not 0 (software), only the button and SMBus bits may wake the system. RTC, PME, general-purpose and ring events set status but do not wake.
- R10: General-purpose inputs marked in `GP_CORE_MASK` (default: inputs 2 and 3) may wake the system only from S1.
- R11: `sleep_req_i` in S0 moves the state to S1, S3, S4 or S5 for `sleep_type_i` = 0, 1, 2 or 3, and sets `s5_entry_o` to 0. The request is ignored in any other state.
- R12: `ovr_i` moves any powered state to S5 with `s5_entry_o` = 2. A wake in that same cycle is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the always-on logic |
| pwr_good_i | input | 1 | Core power good |
| rsm_rst_ni | input | 1 | Resume-well reset, active low |
| pwr_btn_ni | input | 1 | Power button, active low |
| ring_ni | input | 1 | Ring indicate, active low |
| rtc_alarm_i | input | 1 | Alarm event |
| pme_i | input | 1 | Power-management event |
| gp_wake_i | input | NGP | General-purpose wake inputs |
| smb_valid_i | input | 1 | SMBus slave message strobe |
| smb_code_i | input | 8 | SMBus slave message code |
| sleep_req_i | input | 1 | Software sleep command |
| sleep_type_i | input | 2 | Requested sleep state |
| ovr_i | input | 1 | Power-button override |
| stay_off_i | input | 1 | Power-return policy, 1 = stay off |
| en_wr_i | input | 1 | Enable register write |
| en_wdata_i | input | NGP+5 | Enable write data |
| sts_clr_i | input | 1 | Status clear strobe |
| sts_clr_mask_i | input | NGP+5 | Status bits to clear |
| flr_clr_i | input | 2 | Failure flag clear, bit 0 core, bit 1 power |
| wake_o | output | 1 | One-cycle wake request |
| state_o | output | 3 | Current state: 0, 1, 3, 4, 5, or 7 during loss |
| s5_entry_o | output | 2 | S5 entry path: 0 software, 1 power loss, 2 override |
| sts_o | output | NGP+5 | Wake status bits |
| en_o | output | NGP+5 | Wake enable bits |
| core_flr_o | output | 1 | Sticky core power failure flag |
| pwr_flr_o | output | 1 | Sticky resume-well power failure flag |

## Verification
Every output is registered once. A change in the inputs sampled at one rising edge therefore shows on all outputs after that same edge. This holds for status, enables, state, wake and flags alike. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge, and every output is compared a quarter period after each rising edge. This places each expected value exactly one edge after its stimulus. The stimulus steps through every entry path into S5, the core-well gating, loss and return with each policy outcome, and clears that collide with sets.

// File: rtl/wake_pm_pkg.sv
package wake_pm_pkg;
  typedef enum logic [2:0] {
    ST_S0  = 3'd0,
    ST_S1  = 3'd1,
    ST_S3  = 3'd3,
    ST_S4  = 3'd4,
    ST_S5  = 3'd5,
    ST_OFF = 3'd7
  } pm_state_e;

  typedef enum logic [1:0] {
    ENT_SW    = 2'd0,
    ENT_PFAIL = 2'd1,
    ENT_OVR   = 2'd2
  } s5_entry_e;

  localparam int SRC_PB   = 0;
  localparam int SRC_RING = 1;
  localparam int SRC_RTC  = 2;
  localparam int SRC_PME  = 3;
  localparam int SRC_SMB  = 4;
  localparam int SRC_GP0  = 5;

  localparam logic [7:0] SMB_WAKE  = 8'h01;
  localparam logic [7:0] SMB_HRST0 = 8'h03;
  localparam logic [7:0] SMB_HRST1 = 8'h04;
endpackage

// File: rtl/wake_src_decode.sv
module wake_src_decode
  import wake_pm_pkg::*;
#(
  parameter int NGP = 4,
  localparam int NSRC = NGP + 5
) (
  input  logic            pwr_btn_ni,
  input  logic            ring_ni,
  input  logic            rtc_alarm_i,
  input  logic            pme_i,
  input  logic [NGP-1:0]  gp_wake_i,
  input  logic            smb_valid_i,
  input  logic [7:0]      smb_code_i,
  output logic [NSRC-1:0] raw_o
);
  logic smb_hit;

  always_comb begin
    smb_hit = smb_valid_i &&
              (smb_code_i == SMB_WAKE || smb_code_i == SMB_HRST0 || smb_code_i == SMB_HRST1);
  end

  assign raw_o[SRC_PB]   = ~pwr_btn_ni;
  assign raw_o[SRC_RING] = ~ring_ni;
  assign raw_o[SRC_RTC]  = rtc_alarm_i;
  assign raw_o[SRC_PME]  = pme_i;
  assign raw_o[SRC_SMB]  = smb_hit;

  for (genvar g = 0; g < NGP; g++) begin : g_gp
    assign raw_o[SRC_GP0+g] = gp_wake_i[g];
  end
endmodule

// File: rtl/wake_src_regs.sv
module wake_src_regs
  import wake_pm_pkg::*;
#(
  parameter int NGP = 4,
  localparam int NSRC = NGP + 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rsm_rst_ni,
  input  logic [NSRC-1:0] raw_i,
  input  logic            en_wr_i,
  input  logic [NSRC-1:0] en_wdata_i,
  input  logic            sts_clr_i,
  input  logic [NSRC-1:0] sts_clr_mask_i,
  output logic [NSRC-1:0] sts_o,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] rise_o
);
  localparam logic [NSRC-1:0] FIXED_EN = NSRC'(1 << SRC_PB) | NSRC'(1 << SRC_SMB);
  localparam logic [NSRC-1:0] KEEP_EN  = NSRC'(1 << SRC_RTC);

  logic [NSRC-1:0] sts_q, sts_d, en_q, en_d;

  always_comb begin
    sts_d = sts_q;
    en_d  = en_q;
    if (!rsm_rst_ni) begin
      // only a pending ring event survives the loss
      sts_d = '0;
      sts_d[SRC_RING] = sts_q[SRC_RING] | raw_i[SRC_RING];
      en_d  = en_q & KEEP_EN;
    end else begin
      if (sts_clr_i) sts_d = sts_d & ~sts_clr_mask_i;
      sts_d = sts_d | raw_i;
      if (en_wr_i) en_d = en_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  assign sts_o  = sts_q;
  assign en_o   = en_q | FIXED_EN;
  assign rise_o = raw_i & ~sts_q & {NSRC{rsm_rst_ni}};

  // R3
  lost_sts_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsm_rst_ni |=> !sts_o[SRC_PB] && !sts_o[SRC_RTC]);

  // R3
  rtc_en_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsm_rst_ni |=> en_o[SRC_RTC] == $past(en_o[SRC_RTC]));
endmodule

// File: rtl/wake_gate.sv
module wake_gate
  import wake_pm_pkg::*;
#(
  parameter int NGP = 4,
  parameter logic [NGP-1:0] GP_CORE_MASK = 4'b1100,
  localparam int NSRC = NGP + 5
) (
  input  pm_state_e       state_i,
  input  s5_entry_e       entry_i,
  input  logic [NSRC-1:0] en_i,
  output logic [NSRC-1:0] elig_o
);
  logic s5_open;
  logic core_on;

  assign s5_open = !(state_i == ST_S5 && entry_i != ENT_SW);
  assign core_on = (state_i == ST_S1);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == SRC_PB || i == SRC_SMB) begin : g_fixed
      assign elig_o[i] = 1'b1;
    end else if (i >= SRC_GP0) begin : g_gp
      if (GP_CORE_MASK[i-SRC_GP0]) begin : g_core
        assign elig_o[i] = en_i[i] && s5_open && core_on;
      end else begin : g_rsm
        assign elig_o[i] = en_i[i] && s5_open;
      end
    end else begin : g_misc
      assign elig_o[i] = en_i[i] && s5_open;
    end
  end
endmodule

// File: rtl/wake_pm_fsm.sv
module wake_pm_fsm
  import wake_pm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rsm_rst_ni,
  input  logic       pwr_good_i,
  input  logic       stay_off_i,
  input  logic       ring_pend_i,
  input  logic       sleep_req_i,
  input  logic [1:0] sleep_type_i,
  input  logic       ovr_i,
  input  logic       wake_hit_i,
  input  logic [1:0] flr_clr_i,
  output pm_state_e  state_o,
  output s5_entry_e  entry_o,
  output logic       wake_o,
  output logic       core_flr_o,
  output logic       pwr_flr_o
);
  pm_state_e state_q, state_d;
  s5_entry_e entry_q, entry_d;
  logic      was_s4_q, was_s4_d;
  logic      wake_d;
  logic      pg_q;
  logic      core_q, pwr_q;
  logic      in_sleep;
  logic      boot;

  assign in_sleep = (state_q == ST_S1) || (state_q == ST_S3) ||
                    (state_q == ST_S4) || (state_q == ST_S5);
  assign boot     = !stay_off_i || ring_pend_i;

  always_comb begin
    state_d  = state_q;
    entry_d  = entry_q;
    was_s4_d = was_s4_q;
    wake_d   = 1'b0;
    if (!rsm_rst_ni) begin
      if (state_q != ST_OFF) begin
        was_s4_d = (state_q == ST_S4);
        state_d  = ST_OFF;
      end
    end else if (state_q == ST_OFF) begin
      if (boot) begin
        state_d = ST_S0;
        wake_d  = 1'b1;
      end else if (was_s4_q) begin
        state_d = ST_S4;
      end else begin
        state_d = ST_S5;
        entry_d = ENT_PFAIL;
      end
    end else if (ovr_i) begin
      state_d = ST_S5;
      entry_d = ENT_OVR;
    end else if (in_sleep && wake_hit_i) begin
      state_d = ST_S0;
      wake_d  = 1'b1;
    end else if (state_q == ST_S0 && sleep_req_i) begin
      entry_d = ENT_SW;
      unique case (sleep_type_i)
        2'd0:    state_d = ST_S1;
        2'd1:    state_d = ST_S3;
        2'd2:    state_d = ST_S4;
        default: state_d = ST_S5;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_S5;
      entry_q  <= ENT_PFAIL;
      was_s4_q <= 1'b0;
      wake_o   <= 1'b0;
      pg_q     <= 1'b0;
      core_q   <= 1'b0;
      pwr_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      entry_q  <= entry_d;
      was_s4_q <= was_s4_d;
      wake_o   <= wake_d;
      pg_q     <= pwr_good_i;
      core_q   <= (core_q & ~flr_clr_i[0]) | (pg_q & ~pwr_good_i);
      pwr_q    <= (pwr_q & ~flr_clr_i[1]) | ~rsm_rst_ni;
    end
  end

  assign state_o    = state_q;
  assign entry_o    = entry_q;
  assign core_flr_o = core_q;
  assign pwr_flr_o  = pwr_q;

  // R8
  wake_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  // R2
  pwr_flr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsm_rst_ni |=> pwr_flr_o);

  // R5
  off_during_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsm_rst_ni |=> state_o == ST_OFF && !wake_o);
endmodule

// File: rtl/wake_pm_ctrl.sv
module wake_pm_ctrl
  import wake_pm_pkg::*;
#(
  parameter int NGP = 4,
  parameter logic [NGP-1:0] GP_CORE_MASK = 4'b1100,
  localparam int NSRC = NGP + 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_good_i,
  input  logic            rsm_rst_ni,
  input  logic            pwr_btn_ni,
  input  logic            ring_ni,
  input  logic            rtc_alarm_i,
  input  logic            pme_i,
  input  logic [NGP-1:0]  gp_wake_i,
  input  logic            smb_valid_i,
  input  logic [7:0]      smb_code_i,
  input  logic            sleep_req_i,
  input  logic [1:0]      sleep_type_i,
  input  logic            ovr_i,
  input  logic            stay_off_i,
  input  logic            en_wr_i,
  input  logic [NSRC-1:0] en_wdata_i,
  input  logic            sts_clr_i,
  input  logic [NSRC-1:0] sts_clr_mask_i,
  input  logic [1:0]      flr_clr_i,
  output logic            wake_o,
  output logic [2:0]      state_o,
  output logic [1:0]      s5_entry_o,
  output logic [NSRC-1:0] sts_o,
  output logic [NSRC-1:0] en_o,
  output logic            core_flr_o,
  output logic            pwr_flr_o
);
  logic [NSRC-1:0] raw, rise, elig;
  pm_state_e       state;
  s5_entry_e       entry;
  logic            wake_hit;

  wake_src_decode #(.NGP(NGP)) u_decode (
    .pwr_btn_ni  (pwr_btn_ni),
    .ring_ni     (ring_ni),
    .rtc_alarm_i (rtc_alarm_i),
    .pme_i       (pme_i),
    .gp_wake_i   (gp_wake_i),
    .smb_valid_i (smb_valid_i),
    .smb_code_i  (smb_code_i),
    .raw_o       (raw)
  );

  wake_src_regs #(.NGP(NGP)) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rsm_rst_ni     (rsm_rst_ni),
    .raw_i          (raw),
    .en_wr_i        (en_wr_i),
    .en_wdata_i     (en_wdata_i),
    .sts_clr_i      (sts_clr_i),
    .sts_clr_mask_i (sts_clr_mask_i),
    .sts_o          (sts_o),
    .en_o           (en_o),
    .rise_o         (rise)
  );

  wake_gate #(.NGP(NGP), .GP_CORE_MASK(GP_CORE_MASK)) u_gate (
    .state_i (state),
    .entry_i (entry),
    .en_i    (en_o),
    .elig_o  (elig)
  );

  assign wake_hit = |(rise & elig);

  wake_pm_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rsm_rst_ni   (rsm_rst_ni),
    .pwr_good_i   (pwr_good_i),
    .stay_off_i   (stay_off_i),
    .ring_pend_i  (sts_o[SRC_RING]),
    .sleep_req_i  (sleep_req_i),
    .sleep_type_i (sleep_type_i),
    .ovr_i        (ovr_i),
    .wake_hit_i   (wake_hit),
    .flr_clr_i    (flr_clr_i),
    .state_o      (state),
    .entry_o      (entry),
    .wake_o       (wake_o),
    .core_flr_o   (core_flr_o),
    .pwr_flr_o    (pwr_flr_o)
  );

  assign state_o    = state;
  assign s5_entry_o = entry;

  // R9
  s5_locked_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsm_rst_ni && !ovr_i && state == ST_S5 && entry != ENT_SW &&
     !rise[SRC_PB] && !rise[SRC_SMB]) |=> !wake_o);

  // R12
  ovr_to_s5_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsm_rst_ni && ovr_i && state != ST_OFF) |=> state == ST_S5 && entry == ENT_OVR && !wake_o);
endmodule

// File: tb/wake_pm_ctrl_tb.sv
module wake_pm_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NGP   = 4;
  localparam int NSRC  = NGP + 5;
  localparam logic [NGP-1:0] CORE_GP = 4'b1100;
  localparam int WDOG  = 20000;

  logic clk = 0, rst_n = 0;
  logic pwr_good, rsm_n, pb_n, ring_n, rtc, pme, smb_v, sreq, ovr, stay_off, en_wr, clr;
  logic [NGP-1:0] gp;
  logic [7:0] smb_code;
  logic [1:0] stype, flr_clr;
  logic [NSRC-1:0] en_wd, clr_m;

  logic wake;
  logic [2:0] state;
  logic [1:0] entry;
  logic [NSRC-1:0] sts, en;
  logic core_flr, pwr_flr;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  wake_pm_ctrl #(.NGP(NGP), .GP_CORE_MASK(CORE_GP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good), .rsm_rst_ni(rsm_n),
    .pwr_btn_ni(pb_n), .ring_ni(ring_n), .rtc_alarm_i(rtc), .pme_i(pme),
    .gp_wake_i(gp), .smb_valid_i(smb_v), .smb_code_i(smb_code),
    .sleep_req_i(sreq), .sleep_type_i(stype), .ovr_i(ovr), .stay_off_i(stay_off),
    .en_wr_i(en_wr), .en_wdata_i(en_wd), .sts_clr_i(clr), .sts_clr_mask_i(clr_m),
    .flr_clr_i(flr_clr), .wake_o(wake), .state_o(state), .s5_entry_o(entry),
    .sts_o(sts), .en_o(en), .core_flr_o(core_flr), .pwr_flr_o(pwr_flr)
  );

  // behavioural reference model
  int m_state, m_entry;
  bit m_was4, m_wake, m_pg, m_core, m_pwr;
  bit [NSRC-1:0] m_sts, m_en;

  function automatic bit [NSRC-1:0] raw_ev();
    bit [NSRC-1:0] r;
    r = '0;
    r[0] = !pb_n; r[1] = !ring_n; r[2] = rtc; r[3] = pme;
    r[4] = smb_v && (smb_code == 8'h01 || smb_code == 8'h03 || smb_code == 8'h04);
    for (int k = 0; k < NGP; k++) r[5+k] = gp[k];
    return r;
  endfunction

  function automatic bit may_wake(int i);
    bit [NSRC-1:0] e;
    e = m_en | NSRC'(9'h011);
    if (i == 0 || i == 4) return 1;
    if (!e[i]) return 0;
    if (m_state == 5 && m_entry != 0) return 0;
    if (i >= 5 && CORE_GP[i-5] && m_state != 1) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 5; m_entry <= 1; m_was4 <= 0; m_wake <= 0;
      m_pg <= 0; m_core <= 0; m_pwr <= 0; m_sts <= '0; m_en <= '0;
    end else begin
      automatic bit [NSRC-1:0] r = raw_ev();
      automatic bit hit = 0;
      automatic bit sleeping = (m_state == 1 || m_state == 3 || m_state == 4 || m_state == 5);
      automatic int ns = m_state;
      automatic int ne = m_entry;
      automatic bit nw = 0;
      automatic bit n4 = m_was4;
      for (int i = 0; i < NSRC; i++)
        if (rsm_n && r[i] && !m_sts[i] && may_wake(i)) hit = 1;
      if (!rsm_n) begin
        if (m_state != 7) begin n4 = (m_state == 4); ns = 7; end
      end else if (m_state == 7) begin
        if (!stay_off || m_sts[1]) begin ns = 0; nw = 1; end
        else if (m_was4) ns = 4;
        else begin ns = 5; ne = 1; end
      end else if (ovr) begin
        ns = 5; ne = 2;
      end else if (sleeping && hit) begin
        ns = 0; nw = 1;
      end else if (m_state == 0 && sreq) begin
        ne = 0;
        ns = (stype == 0) ? 1 : (stype == 1) ? 3 : (stype == 2) ? 4 : 5;
      end
      if (!rsm_n) begin
        m_sts <= NSRC'(m_sts[1] || r[1]) << 1;
        m_en  <= m_en & NSRC'(9'h004);
      end else begin
        m_sts <= (m_sts & ~(clr ? clr_m : '0)) | r;
        m_en  <= en_wr ? en_wd : m_en;
      end
      m_state <= ns; m_entry <= ne; m_wake <= nw; m_was4 <= n4;
      m_core <= (m_core && !flr_clr[0]) || (m_pg && !pwr_good);
      m_pwr  <= (m_pwr && !flr_clr[1]) || !rsm_n;
      m_pg   <= pwr_good;
    end
  end

  task automatic chk(string nm, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, nm, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      chk("wake", int'(wake), int'(m_wake));
      chk("state", int'(state), m_state);
      chk("entry", int'(entry), m_entry);
      chk("sts", int'(sts), int'(m_sts));
      chk("en", int'(en), int'(m_en | NSRC'(9'h011)));
      chk("core_flr", int'(core_flr), int'(m_core));
      chk("pwr_flr", int'(pwr_flr), int'(m_pwr));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !done) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<%0d", cycles, WDOG);
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr_all();
    clr = 1; clr_m = '1; step(1); clr = 0; clr_m = '0; step(1);
  endtask

  task automatic go_sleep(logic [1:0] t);
    sreq = 1; stype = t; step(1); sreq = 0; step(1);
  endtask

  initial begin
    pwr_good = 0; rsm_n = 0; pb_n = 1; ring_n = 1; rtc = 0; pme = 0; gp = '0;
    smb_v = 0; smb_code = '0; sreq = 0; stype = '0; ovr = 0; stay_off = 1;
    en_wr = 0; en_wd = '0; clr = 0; clr_m = '0; flr_clr = '0;
    step(2);
    // R1: reset values
    cur_req = "R1";
    chk("rst_state", int'(state), 5);
    chk("rst_entry", int'(entry), 1);
    chk("rst_sts", int'(sts), 0);
    chk("rst_en", int'(en), 'h011);
    chk("rst_wake", int'(wake), 0);
    chk("rst_flags", int'({core_flr, pwr_flr}), 0);
    rst_n = 1;
    // R2: loss held, power flag sets
    cur_req = "R2";
    step(3);
    // R5: return with stay-off policy, S5 by power loss
    cur_req = "R5";
    rsm_n = 1; step(2); pwr_good = 1; step(2);
    // R7: enable write, fixed bits
    cur_req = "R7";
    en_wr = 1; en_wd = '1; step(1); en_wr = 0; step(1);
    // R9: power-loss S5 blocks rtc, pme, gp, ring
    cur_req = "R9";
    rtc = 1; step(1); rtc = 0; pme = 1; step(1); pme = 0;
    gp[0] = 1; ring_n = 0; step(1); gp[0] = 0; ring_n = 1; step(2);
    // R6: clear colliding with set, ignored SMBus code
    cur_req = "R6";
    clr = 1; clr_m = '1; rtc = 1; step(1); clr = 0; rtc = 0; clr_m = '0;
    smb_v = 1; smb_code = 8'h02; step(1); smb_v = 0; step(1);
    // R8: button wakes
    cur_req = "R8";
    pb_n = 0; step(1); pb_n = 1; step(2);
    pulse_clr_all();
    // R11: sleep S3, ignored second request, gp wake
    cur_req = "R11";
    go_sleep(2'd1); go_sleep(2'd0);
    gp[1] = 1; step(1); gp[1] = 0; step(2);
    pulse_clr_all();
    // R10: core-well gp wakes from S1 only
    cur_req = "R10";
    go_sleep(2'd0); gp[3] = 1; step(1); gp[3] = 0; step(1);
    pulse_clr_all();
    go_sleep(2'd1); gp[2] = 1; step(1); gp[2] = 0; step(2);
    cur_req = "R8";
    ring_n = 0; step(1); ring_n = 1; step(1);
    pulse_clr_all();
    // R9: software S5 allows rtc
    cur_req = "R9";
    go_sleep(2'd3); rtc = 1; step(1); rtc = 0; step(1);
    pulse_clr_all();
    // R12: override S5, only SMBus/button wake
    cur_req = "R12";
    ovr = 1; step(1); ovr = 0; step(1);
    rtc = 1; pme = 1; step(1); rtc = 0; pme = 0;
    smb_v = 1; smb_code = 8'h03; step(1); smb_v = 0; step(1);
    pulse_clr_all();
    go_sleep(2'd0); ovr = 1; gp[0] = 1; step(1); ovr = 0; gp[0] = 0; step(1);
    smb_v = 1; smb_code = 8'h04; step(1); smb_v = 0; step(1);
    pulse_clr_all();
    go_sleep(2'd1); smb_v = 1; smb_code = 8'h01; step(1); smb_v = 0; step(1);
    pulse_clr_all();
    // R3: loss from S4, enables wiped except alarm, writes ignored
    cur_req = "R3";
    go_sleep(2'd2);
    rsm_n = 0; pwr_good = 0; en_wr = 1; en_wd = '0; step(1); en_wr = 0; step(2);
    cur_req = "R5";
    rsm_n = 1; step(2); pwr_good = 1; step(1);
    pb_n = 0; step(1); pb_n = 1; step(1);
    // R2: flag clear, collision with set
    cur_req = "R2";
    flr_clr = 2'b11; step(1); flr_clr = '0; step(1);
    pwr_good = 0; flr_clr = 2'b01; step(1); flr_clr = '0; pwr_good = 1; step(1);
    flr_clr = 2'b01; step(1); flr_clr = '0; step(1);
    pulse_clr_all();
    // R4: ring during loss forces boot
    cur_req = "R4";
    rsm_n = 0; ring_n = 0; step(2); ring_n = 1; step(1); rsm_n = 1; step(2);
    pulse_clr_all();
    // R5: boot policy, then stay-off from S0
    cur_req = "R5";
    stay_off = 0; rsm_n = 0; step(2); rsm_n = 1; step(2);
    stay_off = 1; rsm_n = 0; step(2); rsm_n = 1; step(3);
    finish_run();
  end
endmodule